// File: doc/BRIEF.md
# Configurable Interrupt Status Controller

This block collects single-bit interrupt sources, arranged in groups of register-width lanes, into sticky status registers, and merges them into one interrupt pin. For each source it keeps an enable bit and a 2-bit trigger code. The trigger code chooses whether the source records an event when its condition appears (rising), when the condition goes away (falling), or for as long as the condition holds (level). The high and low halves of each trigger code live in two separate registers, at the source's own bit position.

Software reaches every register through a simple port with an address, a write strobe and a read strobe. Reading a group's status register returns the latched events and clears them in the same cycle. A level-triggered source whose condition is still true stays set after the clear. A 2-bit pin-control field selects the polarity of the combined pin and can also hold the pin at 0. With the default parameters there are two groups. Group 0 has live sources at bit positions 6, 2 and 0. Group 1 has live sources at bit positions 3 and 1. Every other position is inert and reads 0.

Top module: `isc_irq_ctrl`

## Requirements
- R1: After reset, every status, enable, trigger-code and pin-control register reads 0, and the pin is 0.
- R2: With trigger code 00 (rising) and the enable bit at 1, a 0-to-1 change of the source sets its status bit. The bit stays set after the source returns to 0, until a status read.
- R3: With trigger code 01 (falling) and the enable bit at 1, a 1-to-0 change of the source sets its status bit. A 0-to-1 change leaves the bit at 0.
- R4: With trigger code 10 (level) and the enable bit at 1, the status bit is set while the source is 1. A status read does not clear the bit while the source is still 1. The next read after the source falls returns 1, and the read after that returns 0.
- R5: A status read returns the value held before the read's clock edge and clears the register. An event detected at that same edge is kept and appears in the next read.
- R6: A status bit whose enable bit is 0 reads 0 and does not affect the pin. Clearing an enable bit also clears its latched status bit.
- R7: Trigger code 11 never sets the status bit and never drives the pin, whatever the source does.
- R8: Register map for group g (g = 0, 1): status at address 4g, enable at 4g+1, trigger-code high bits at 4g+2, trigger-code low bits at 4g+3. Pin control sits in bits 1:0 of address 8. Each source uses the same bit position in all four registers of its group. All other addresses read 0.
- R9: Inert bit positions (every group-0 bit other than 6, 2 and 0, and every group-1 bit other than 3 and 1) ignore writes and always read 0 in every register.
- R10: Pin control 00 makes the pin active-high, 01 makes it active-low, and 10 or 11 hold the pin at 0.
- R11: The combined interrupt is active when any status bit is 1, or when any enabled level-triggered source is 1 in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NGRP*W (16) | Interrupt conditions; group g occupies bits g*W +: W |
| addr_i | input | AW (4) | Register address |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | W (8) | Write data |
| rd_en_i | input | 1 | Read strobe; data is valid in the cycle after the strobe |
| rd_data_o | output | W (8) | Read data, held until the next read |
| irq_o | output | 1 | Combined interrupt pin |

## Verification
Every live source is swept through all four trigger codes, with its enable bit both set and clear. Each combination goes through the same pulse: raise the source, read, lower it, read, read again. The three read values and the pin level tell rising, falling, level and reserved apart, and also show that the enable bit suppresses the source. Separate patterns cover the following: all sources driven high at once, which exposes inert bits; an edge that lands in the same cycle as the clearing read; an enable bit cleared while its status is latched; and all four pin-control codes, tried with the status set and with it clear.

// File: rtl/isc_pkg.sv
package isc_pkg;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'b00,
    TRIG_FALL  = 2'b01,
    TRIG_LEVEL = 2'b10,
    TRIG_RSVD  = 2'b11
  } trig_e;

  typedef enum logic [1:0] {
    PIN_HIGH = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_OFF2 = 2'b10,
    PIN_OFF3 = 2'b11
  } pin_e;

  localparam int REGS_PER_GRP = 4;
  localparam int OFS_STATUS   = 0;
  localparam int OFS_ENABLE   = 1;
  localparam int OFS_CODE_HI  = 2;
  localparam int OFS_CODE_LO  = 3;

endpackage

// File: rtl/isc_trigger.sv
module isc_trigger
  import isc_pkg::*;
(
  input  logic  src_i,
  input  logic  src_d_i,
  input  trig_e code_i,
  output logic  evt_o,
  output logic  lvl_o
);

  always_comb begin
    evt_o = 1'b0;
    lvl_o = 1'b0;
    unique case (code_i)
      TRIG_RISE:  evt_o = src_i & ~src_d_i;
      TRIG_FALL:  evt_o = ~src_i & src_d_i;
      TRIG_LEVEL: begin
        evt_o = src_i;
        lvl_o = src_i;
      end
      default:    evt_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/isc_group.sv
module isc_group
  import isc_pkg::*;
#(
  parameter int          W    = 8,
  parameter logic [W-1:0] USED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wr_enable_i,
  input  logic         wr_code_hi_i,
  input  logic         wr_code_lo_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] code_hi_o,
  output logic [W-1:0] code_lo_o,
  output logic [W-1:0] lvl_hot_o
);

  logic [W-1:0] src_q;
  logic [W-1:0] enable_q;
  logic [W-1:0] code_hi_q;
  logic [W-1:0] code_lo_q;
  logic [W-1:0] status_q;
  logic [W-1:0] evt;
  logic [W-1:0] lvl;
  logic [W-1:0] enable_n;
  logic [W-1:0] status_n;

  for (genvar i = 0; i < W; i++) begin : g_lane
    if (USED[i]) begin : g_live
      isc_trigger u_trig (
        .src_i   (src_i[i]),
        .src_d_i (src_q[i]),
        .code_i  (trig_e'({code_hi_q[i], code_lo_q[i]})),
        .evt_o   (evt[i]),
        .lvl_o   (lvl[i])
      );
    end else begin : g_inert
      assign evt[i] = 1'b0;
      assign lvl[i] = 1'b0;
    end
  end

  assign enable_n = wr_enable_i ? (wdata_i & USED) : enable_q;

  always_comb begin
    status_n = clr_i ? '0 : status_q;
    status_n = status_n | (evt & enable_q);
    status_n = status_n & enable_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      enable_q  <= '0;
      code_hi_q <= '0;
      code_lo_q <= '0;
      status_q  <= '0;
    end else begin
      src_q    <= src_i & USED;
      enable_q <= enable_n;
      status_q <= status_n;
      if (wr_code_hi_i) code_hi_q <= wdata_i & USED;
      if (wr_code_lo_i) code_lo_q <= wdata_i & USED;
    end
  end

  assign status_o  = status_q;
  assign enable_o  = enable_q;
  assign code_hi_o = code_hi_q;
  assign code_lo_o = code_lo_q;
  assign lvl_hot_o = lvl & enable_q;

endmodule

// File: rtl/isc_pin.sv
module isc_pin
  import isc_pkg::*;
(
  input  pin_e ctrl_i,
  input  logic any_i,
  output logic pin_o
);

  always_comb begin
    unique case (ctrl_i)
      PIN_HIGH: pin_o = any_i;
      PIN_LOW:  pin_o = ~any_i;
      default:  pin_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/isc_irq_ctrl.sv
module isc_irq_ctrl
  import isc_pkg::*;
#(
  parameter int                 W    = 8,
  parameter int                 NGRP = 2,
  parameter int                 AW   = 4,
  parameter logic [NGRP*W-1:0]  USED = 16'h0A45
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NGRP*W-1:0] src_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              rd_en_i,
  output logic [W-1:0]      rd_data_o,
  output logic              irq_o
);

  localparam int TOT       = NGRP * W;
  localparam int CTRL_ADDR = NGRP * REGS_PER_GRP;

  logic [TOT-1:0] all_status;
  logic [TOT-1:0] all_enable;
  logic [TOT-1:0] all_code_hi;
  logic [TOT-1:0] all_code_lo;
  logic [TOT-1:0] all_lvl_hot;
  pin_e           pin_ctrl_q;
  logic [W-1:0]   rd_mux;
  logic [W-1:0]   rd_q;
  logic           irq_any;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int BASE = g * REGS_PER_GRP;
    logic hit_status, hit_enable, hit_hi, hit_lo;

    assign hit_status = (addr_i == AW'(BASE + OFS_STATUS));
    assign hit_enable = (addr_i == AW'(BASE + OFS_ENABLE));
    assign hit_hi     = (addr_i == AW'(BASE + OFS_CODE_HI));
    assign hit_lo     = (addr_i == AW'(BASE + OFS_CODE_LO));

    isc_group #(
      .W    (W),
      .USED (USED[g*W +: W])
    ) u_group (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_i        (src_i[g*W +: W]),
      .wdata_i      (wr_data_i),
      .wr_enable_i  (wr_en_i & hit_enable),
      .wr_code_hi_i (wr_en_i & hit_hi),
      .wr_code_lo_i (wr_en_i & hit_lo),
      .clr_i        (rd_en_i & hit_status),
      .status_o     (all_status[g*W +: W]),
      .enable_o     (all_enable[g*W +: W]),
      .code_hi_o    (all_code_hi[g*W +: W]),
      .code_lo_o    (all_code_lo[g*W +: W]),
      .lvl_hot_o    (all_lvl_hot[g*W +: W])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (addr_i == AW'(g * REGS_PER_GRP + OFS_STATUS))  rd_mux = all_status[g*W +: W];
      if (addr_i == AW'(g * REGS_PER_GRP + OFS_ENABLE))  rd_mux = all_enable[g*W +: W];
      if (addr_i == AW'(g * REGS_PER_GRP + OFS_CODE_HI)) rd_mux = all_code_hi[g*W +: W];
      if (addr_i == AW'(g * REGS_PER_GRP + OFS_CODE_LO)) rd_mux = all_code_lo[g*W +: W];
    end
    if (addr_i == AW'(CTRL_ADDR)) rd_mux = {{(W-2){1'b0}}, pin_ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= '0;
      pin_ctrl_q <= PIN_HIGH;
    end else begin
      if (rd_en_i) rd_q <= rd_mux;
      if (wr_en_i && addr_i == AW'(CTRL_ADDR)) pin_ctrl_q <= pin_e'(wr_data_i[1:0]);
    end
  end

  assign irq_any   = (|all_status) | (|all_lvl_hot);
  assign rd_data_o = rd_q;

  isc_pin u_pin (
    .ctrl_i (pin_ctrl_q),
    .any_i  (irq_any),
    .pin_o  (irq_o)
  );

endmodule

// File: rtl/isc_irq_checker.sv
module isc_irq_checker
  import isc_pkg::*;
#(
  parameter int                W    = 8,
  parameter int                NGRP = 2,
  parameter int                AW   = 4,
  parameter logic [NGRP*W-1:0] USED = 16'h0A45
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NGRP*W-1:0] src_i,
  input logic [AW-1:0]     addr_i,
  input logic              rd_en_i,
  input logic              irq_o,
  input logic [NGRP*W-1:0] all_status,
  input logic [NGRP*W-1:0] all_enable,
  input logic [NGRP*W-1:0] all_code_hi,
  input logic [NGRP*W-1:0] all_code_lo,
  input logic [1:0]        pin_ctrl_q
);

  for (genvar i = 0; i < NGRP*W; i++) begin : g_bit
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ({all_code_hi[i], all_code_lo[i]} == 2'b00 && all_enable[i] && $rose(src_i[i]) && USED[i])
      |=> all_status[i]);

    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ({all_code_hi[i], all_code_lo[i]} == 2'b01 && all_enable[i] && $fell(src_i[i]) && USED[i])
      |=> all_status[i]);

    p_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ({all_code_hi[i], all_code_lo[i]} == 2'b10 && all_enable[i] && src_i[i] && USED[i])
      |=> all_status[i]);

    p_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ({all_code_hi[i], all_code_lo[i]} == 2'b11 && !all_status[i])
      |=> !all_status[i]);
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && addr_i == AW'(g * REGS_PER_GRP) &&
       src_i[g*W +: W] == '0 && $past(src_i[g*W +: W]) == '0)
      |=> all_status[g*W +: W] == '0);
  end

  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (all_status & ~all_enable) == '0);

  p_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((all_status | all_enable | all_code_hi | all_code_lo) & ~USED) == '0);

  p_pin_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ctrl_q[1] |-> !irq_o);

  p_pin_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ctrl_q == 2'b00 && |all_status) |-> irq_o);

endmodule

bind isc_irq_ctrl isc_irq_checker #(
  .W    (W),
  .NGRP (NGRP),
  .AW   (AW),
  .USED (USED)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_i       (src_i),
  .addr_i      (addr_i),
  .rd_en_i     (rd_en_i),
  .irq_o       (irq_o),
  .all_status  (all_status),
  .all_enable  (all_enable),
  .all_code_hi (all_code_hi),
  .all_code_lo (all_code_lo),
  .pin_ctrl_q  (pin_ctrl_q)
);

// File: tb/tb_isc_irq_ctrl.sv
module tb_isc_irq_ctrl;

  localparam logic [15:0] USED_T = 16'h0A45;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        irq;
  int          nchk = 0;
  int          nfail = 0;

  always #10 clk = ~clk;

  isc_irq_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wdata),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data),
    .irq_o     (irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    #3_000_000;
    nfail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of all registers and the pin
    for (int a = 0; a < 9; a++) begin
      rd(a, d);
      chk("R1 reset readback", d, 8'h00);
    end
    chk("R1 reset pin", {7'd0, irq}, 8'h00);

    // R8 / R9: map positions and inert bits on readback
    wr(1, 8'hFF); rd(1, d); chk("R8 R9 enable g0", d, 8'h45);
    wr(6, 8'hFF); rd(6, d); chk("R8 R9 code hi g1", d, 8'h0A);
    wr(3, 8'hFF); rd(3, d); chk("R8 R9 code lo g0", d, 8'h45);
    wr(8, 8'hFF); rd(8, d); chk("R8 pin ctrl", d, 8'h03);
    rd(12, d); chk("R8 unmapped addr", d, 8'h00);
    wr(8, 8'h00); wr(3, 8'h00); wr(6, 8'h00); wr(1, 8'h00);

    // R9 / R4: every source level-triggered and high at once
    wr(1, 8'hFF); wr(5, 8'hFF); wr(2, 8'hFF); wr(6, 8'hFF);
    src = 16'hFFFF;
    rd(0, d); chk("R9 R4 status g0", d, 8'h45);
    rd(4, d); chk("R9 R4 status g1", d, 8'h0A);
    src = '0;
    rd(0, d); rd(4, d);
    rd(0, d); chk("R4 status g0 drains", d, 8'h00);
    rd(4, d); chk("R4 status g1 drains", d, 8'h00);
    wr(2, 8'h00); wr(6, 8'h00); wr(1, 8'h00); wr(5, 8'h00);

    // R2 R3 R4 R6 R7: sweep every live source, code and enable value
    for (int g = 0; g < 2; g++) begin
      for (int b = 0; b < 8; b++) begin
        if (USED_T[g*8+b]) begin
          for (int code = 0; code < 4; code++) begin
            for (int m = 0; m < 2; m++) begin
              logic [7:0] bitv;
              logic e1, e2, ep;
              bitv = 8'(1 << b);
              wr(g*4+1, m ? bitv : 8'h00);
              wr(g*4+2, code[1] ? bitv : 8'h00);
              wr(g*4+3, code[0] ? bitv : 8'h00);
              rd(g*4, d);
              ep = (m == 1) && (code == 0 || code == 2);
              e1 = ep;
              e2 = (m == 1) && (code == 1 || code == 2);
              @(negedge clk);
              src[g*8+b] = 1'b1;
              @(negedge clk);
              chk($sformatf("R11 R2 R4 R6 R7 pin g%0d b%0d c%0d m%0d", g, b, code, m),
                  {7'd0, irq}, {7'd0, ep});
              rd(g*4, d);
              chk($sformatf("R2 R4 R6 R7 read1 g%0d b%0d c%0d m%0d", g, b, code, m),
                  d, e1 ? bitv : 8'h00);
              src[g*8+b] = 1'b0;
              rd(g*4, d);
              chk($sformatf("R3 R4 R5 read2 g%0d b%0d c%0d m%0d", g, b, code, m),
                  d, e2 ? bitv : 8'h00);
              rd(g*4, d);
              chk($sformatf("R5 read3 g%0d b%0d c%0d m%0d", g, b, code, m), d, 8'h00);
              chk($sformatf("R11 idle pin g%0d b%0d c%0d m%0d", g, b, code, m),
                  {7'd0, irq}, 8'h00);
            end
          end
        end
      end
    end
    wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
    wr(5, 8'h00); wr(6, 8'h00); wr(7, 8'h00);

    // R5: rising edge in the same cycle as the clearing read
    wr(1, 8'h01);
    @(negedge clk);
    src[0] = 1'b1; addr = 4'd0; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R5 same-cycle read value", rd_data, 8'h00);
    rd(0, d); chk("R5 same-cycle event kept", d, 8'h01);
    src[0] = 1'b0;
    rd(0, d);

    // R6: clearing the enable bit drops a latched status bit
    wr(1, 8'h04);
    src[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 latched pin", {7'd0, irq}, 8'h01);
    wr(1, 8'h00);
    chk("R6 pin after disable", {7'd0, irq}, 8'h00);
    rd(0, d); chk("R6 status after disable", d, 8'h00);
    src[2] = 1'b0;

    // R10: pin polarity with status set, then clear
    wr(1, 8'h40);
    src[6] = 1'b1;
    @(negedge clk); @(negedge clk);
    src[6] = 1'b0;
    for (int c = 0; c < 4; c++) begin
      wr(8, 8'(c));
      chk($sformatf("R10 pin ctrl %0d status set", c), {7'd0, irq},
          (c == 0) ? 8'h01 : 8'h00);
    end
    rd(0, d); chk("R10 status before clear", d, 8'h40);
    for (int c = 0; c < 4; c++) begin
      wr(8, 8'(c));
      chk($sformatf("R10 pin ctrl %0d status clear", c), {7'd0, irq},
          (c == 1) ? 8'h01 : 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule